// File: doc/BRIEF.md
# Serial Clock Divider With Duty Shaping

This block turns a fast system clock into the bit clock of a serial-peripheral master. The clock period is a programmable whole number N of system cycles. Within each period, the number of cycles spent at the active level comes from an 8-bit duty setting, counted in 1/256 steps of the period. A two-bit mode picks the idle level (the polarity) and whether data is launched on the leading edge or on the trailing edge (the phase). Two strobes, one system cycle wide, tell the shift engine when to drive the next bit (launch) and when to capture the incoming bit (sample).

Another block turns a requested frequency into the nearest achievable divider. This block only takes the resulting integer. Divider, duty and mode are captured at the start of each period, so a change never cuts a period short. Dropping the enable also lets the current period finish. With N=1 the system clock itself is passed through and the duty setting has no effect.

Top module: `serclk_gen`

## Requirements
- R1: While enabled with N>1, every period lasts exactly N system cycles. The first period starts on the first clock edge that sees `en` high.
- R2: For N>1 the number of active cycles at the start of each period is H = round(N*D/256), clamped to the range 1..N-1. D is the duty setting.
- R3: A duty setting of 0 gives the same waveform as a setting of 128.
- R4: `mode[1]` is the polarity. The idle level of `sclk` equals `mode[1]`, and the active level is its inverse. Mode values 0..3 stand for (polarity, phase) = (0,0), (0,1), (1,0), (1,1).
- R5: For N>1, the leading edge is the cycle that starts a period and the trailing edge is cycle H of that period. With `mode[0]`=0, `sample` pulses on the leading edge and `launch` pulses on the trailing edge. With `mode[0]`=1 the two are swapped.
- R6: With N=1, `sclk` is the active level while the system clock is high and the idle level while it is low. `launch` and `sample` are both high on every cycle, and the duty setting is ignored.
- R7: While the block is not running, `sclk` sits at `mode[1]` and neither strobe pulses. This includes the state right after reset.
- R8: A new divider, duty or mode applies only from the next period. A drop of `en` in the middle of a period lets that period finish in full before the clock goes idle.
- R9: A divider value of 0 acts as N=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run request |
| div_n | input | DIV_W | Divider N |
| duty | input | 8 | Active time in 1/256 of the period (0 means 128) |
| mode | input | 2 | {polarity, phase} |
| sclk | output | 1 | Serial clock |
| launch | output | 1 | One-cycle strobe: drive the next bit |
| sample | output | 1 | One-cycle strobe: capture the incoming bit |

## Verification
A wrong period counter shows at once: the next leading-edge strobe arrives early or late, so the whole waveform slides within the first period. A wrong stored active count, or a wrong clamp, moves the trailing strobe and the `sclk` fall inside the first period that uses it. Configuration latched at the wrong moment shows up in the very period where the change was made, because that period has the wrong shape. A stop handled wrongly leaves the clock idle too soon, or lets strobes pulse after the final period.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

  // Divider as applied: zero is treated as one.
  function automatic logic [15:0] eff_div(input logic [15:0] n);
    return (n == 16'd0) ? 16'd1 : n;
  endfunction

  // Active cycles per period: rounded N*D/256, kept inside 1..N-1.
  function automatic logic [15:0] high_count(input logic [15:0] n, input logic [7:0] duty);
    logic [7:0]  d;
    logic [23:0] p;
    logic [15:0] h;
    d = (duty == 8'd0) ? 8'd128 : duty;
    p = 24'(n) * 24'(d) + 24'd128;
    h = 16'(p >> 8);
    if (n <= 16'd1)      h = 16'd1;
    else if (h == 16'd0) h = 16'd1;
    else if (h >= n)     h = n - 16'd1;
    return h;
  endfunction

endpackage

// File: rtl/serclk_cfg.sv
module serclk_cfg #(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] div_n,
  input  logic [7:0]       duty,
  output logic [DIV_W-1:0] n_eff,
  output logic [DIV_W-1:0] hi_eff
);
  import serclk_pkg::*;

  logic [15:0] n16;

  always_comb begin
    n16    = eff_div(16'(div_n));
    n_eff  = DIV_W'(n16);
    hi_eff = DIV_W'(high_count(n16, duty));
  end
endmodule

// File: rtl/serclk_counter.sv
module serclk_counter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] n_eff,
  input  logic [DIV_W-1:0] hi_eff,
  input  logic [1:0]       mode,
  output logic             run,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] n_q,
  output logic [DIV_W-1:0] hi_q,
  output logic             pol_q,
  output logic             pha_q,
  output logic             wrap_evt
);
  assign wrap_evt = run && (cnt == n_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      n_q   <= DIV_W'(1);
      hi_q  <= DIV_W'(1);
      pol_q <= 1'b0;
      pha_q <= 1'b0;
    end else if (!run || wrap_evt) begin
      cnt <= '0;
      run <= en;
      if (en) begin
        n_q   <= n_eff;
        hi_q  <= hi_eff;
        pol_q <= mode[1];
        pha_q <= mode[0];
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/serclk_edges.sv
module serclk_edges #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             run,
  input  logic [DIV_W-1:0] cnt,
  input  logic [DIV_W-1:0] n_q,
  input  logic [DIV_W-1:0] hi_q,
  input  logic             pol_q,
  input  logic             pha_q,
  input  logic             idle_pol,
  output logic             lead_evt,
  output logic             trail_evt,
  output logic             sclk,
  output logic             launch,
  output logic             sample
);
  logic pass;
  logic active;

  always_comb begin
    pass      = (n_q == DIV_W'(1));
    lead_evt  = run && (cnt == '0);
    trail_evt = run && (pass || (cnt == hi_q));
    active    = pass ? clk : (cnt < hi_q);
    sclk      = run ? (pol_q ^ active) : idle_pol;
    launch    = pha_q ? lead_evt : trail_evt;
    sample    = pha_q ? trail_evt : lead_evt;
  end
endmodule

// File: rtl/serclk_gen.sv
module serclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_n,
  input  logic [7:0]       duty,
  input  logic [1:0]       mode,
  output logic             sclk,
  output logic             launch,
  output logic             sample
);
  logic [DIV_W-1:0] n_eff, hi_eff, cnt, n_q, hi_q;
  logic run, pol_q, pha_q, wrap_evt, lead_evt, trail_evt;

  serclk_cfg #(.DIV_W(DIV_W)) u_cfg (
    .div_n(div_n), .duty(duty), .n_eff(n_eff), .hi_eff(hi_eff)
  );

  serclk_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .n_eff(n_eff), .hi_eff(hi_eff),
    .mode(mode), .run(run), .cnt(cnt), .n_q(n_q), .hi_q(hi_q),
    .pol_q(pol_q), .pha_q(pha_q), .wrap_evt(wrap_evt)
  );

  serclk_edges #(.DIV_W(DIV_W)) u_edg (
    .clk(clk), .run(run), .cnt(cnt), .n_q(n_q), .hi_q(hi_q),
    .pol_q(pol_q), .pha_q(pha_q), .idle_pol(mode[1]),
    .lead_evt(lead_evt), .trail_evt(trail_evt),
    .sclk(sclk), .launch(launch), .sample(sample)
  );
endmodule

// File: rtl/serclk_chk.sv
module serclk_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             sclk,
  input logic             launch,
  input logic             sample,
  input logic             run,
  input logic [DIV_W-1:0] n_q,
  input logic [DIV_W-1:0] hi_q,
  input logic             pol_q,
  input logic             wrap_evt,
  input logic             lead_evt
);
  assert_next_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && en) |=> lead_evt);

  assert_hi_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && n_q > DIV_W'(1)) |-> (hi_q >= DIV_W'(1) && hi_q < n_q));

  assert_lead_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_evt && n_q > DIV_W'(1)) |-> (sclk != pol_q));

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && n_q > DIV_W'(1)) |-> !(launch && sample));

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !en) |=> (!launch && !sample));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap_evt) |=> ($stable(n_q) && $stable(hi_q) && $stable(pol_q)));
endmodule

bind serclk_gen serclk_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sclk(sclk), .launch(launch),
  .sample(sample), .run(run), .n_q(n_q), .hi_q(hi_q), .pol_q(pol_q),
  .wrap_evt(wrap_evt), .lead_evt(lead_evt)
);

// File: tb/serclk_gen_bench.sv
module serclk_gen_bench;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [DIV_W-1:0] div_n = 8'd4;
  logic [7:0] duty = 8'd0;
  logic [1:0] mode = 2'd0;
  logic sclk, launch, sample;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serclk_gen #(.DIV_W(DIV_W)) u_serclk_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .div_n(div_n), .duty(duty),
    .mode(mode), .sclk(sclk), .launch(launch), .sample(sample)
  );

  function automatic int exp_hi(input int n, input int d);
    int dd, h;
    dd = (d == 0) ? 128 : d;
    h = (2 * n * dd + 256) / 512;
    if (h < 1) h = 1;
    if (h > n - 1) h = n - 1;
    return h;
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Enable and run; the duty changes to d2 after sample 1, en drops after sample stop_i.
  task automatic run_case(input string tag, input int dv, input int d, input int d2,
                          input int m, input int stop_i);
    int n, pol, pha, total, bad_i, bad_a, bad_e;
    bit ok;
    n = (dv == 0) ? 1 : dv;
    pol = (m >> 1) & 1;
    pha = m & 1;
    total = ((stop_i / n) + 1) * n;
    ok = 1'b1; bad_i = 0; bad_a = 0; bad_e = 0;
    @(negedge clk);
    div_n = DIV_W'(dv); duty = 8'(d); mode = 2'(m); en = 1'b1;
    for (int i = 0; i < total; i++) begin
      int ph, hi, act, lead, trail, e_sclk, e_l, e_s, got;
      @(posedge clk); #1;
      ph = i % n;
      hi = (n == 1) ? 1 : exp_hi(n, (i < n) ? d : d2);
      act = (n == 1) ? 1 : ((ph < hi) ? 1 : 0);
      lead = (ph == 0) ? 1 : 0;
      trail = (n == 1 || ph == hi) ? 1 : 0;
      e_sclk = pol ^ act;
      e_l = pha ? lead : trail;
      e_s = pha ? trail : lead;
      got = {sclk, launch, sample};
      if (ok && got != ((e_sclk << 2) | (e_l << 1) | e_s)) begin
        ok = 1'b0; bad_i = i; bad_a = got; bad_e = (e_sclk << 2) | (e_l << 1) | e_s;
      end
      if (n == 1) begin
        @(negedge clk); #1;
        if (ok && sclk != 1'(pol)) begin
          ok = 1'b0; bad_i = i; bad_a = sclk; bad_e = pol;
        end
      end
      if (i == 1) duty = 8'(d2);
      if (i == stop_i) en = 1'b0;
    end
    if (!ok) $display("  %s first mismatch at cycle %0d ({sclk,launch,sample})", tag, bad_i);
    check(tag, ok, bad_a, bad_e);
    ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      if (sclk != 1'(pol) || launch || sample) ok = 1'b0;
    end
    check({tag, " idle R7 R8"}, ok, {sclk, launch, sample}, pol << 2);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    #23 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R7 reset idle mode0", sclk == 1'b0 && !launch && !sample, {sclk, launch, sample}, 0);
    mode = 2'd2; #1;
    check("R7 R4 idle follows polarity", sclk == 1'b1 && !launch && !sample, {sclk, launch, sample}, 4);
    repeat (3) @(posedge clk);
    #1 check("R7 no strobes while disabled", !launch && !sample, {launch, sample}, 0);

    run_case("R1 R2 R5 n4 d128 m0", 4, 128, 128, 0, 11);
    run_case("R2 R4 R5 n5 d64 m3", 5, 64, 64, 3, 14);
    run_case("R2 clamp low n12 d1 m1", 12, 1, 1, 1, 23);
    run_case("R2 clamp high n2 d255 m2", 2, 255, 255, 2, 5);
    run_case("R3 duty0 n7 m0", 7, 0, 0, 0, 13);
    run_case("R3 duty128 n7 m0", 7, 128, 128, 0, 13);
    run_case("R6 pass n1 m0", 1, 200, 200, 0, 5);
    run_case("R6 pass n1 m3", 1, 10, 10, 3, 5);
    run_case("R9 div0 m2", 0, 77, 77, 2, 4);
    run_case("R8 duty change n8", 8, 32, 224, 1, 23);
    run_case("R8 early stop n6", 6, 128, 128, 2, 7);

    for (int r = 0; r < 24; r++) begin
      int dv, d, m;
      dv = 2 + int'($urandom_range(0, 14));
      d = int'($urandom_range(0, 255));
      m = int'($urandom_range(0, 3));
      run_case($sformatf("R1 R2 R4 R5 random n%0d d%0d m%0d", dv, d, m), dv, d, d, m, 3 * dv - 1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule